// File: doc/BRIEF.md
# Single-Operand Byte/Word ALU

This unit performs the one-operand arithmetic and logic group of a 16-bit processor datapath. The caller presents an operation code, a byte/word select, the operand value and the current N and C condition flags. The unit computes the new value and the four condition flags in one combinational stage. On a valid strobe it captures them into output registers, and `done` marks the cycle in which they are available.

Two computation lanes run side by side, one for the full word and one for the low byte. Byte-mode operations change only the low half, and the high half of the operand is passed through unchanged. The test operation updates only the flags. The byte exchange always acts on the whole word.

Top module: `sop_alu_top`

## Requirements
- R1: While `rst` is high at a clock edge, `result` and `flags` clear to zero and `done` is low after that edge.
- R2: Opcodes: 0 clear, 1 test, 2 increment, 3 decrement, 4 negate, 5 complement, 6 arithmetic shift right, 7 shift left, 8 rotate right, 9 rotate left, 10 byte exchange, 11 add carry, 12 subtract carry, 13 sign extend. `flags` is {N,Z,V,C} with N at bit 3 and C at bit 0. A `valid` at an edge loads `result` and `flags` at that edge and raises `done` for one cycle. Without `valid`, both outputs hold.
- R3: With `byte_mode` high, every opcode except 10 works on bits 7:0. N is taken from bit 7, Z from the low byte, and `result[15:8]` equals `operand[15:8]`.
- R4: Clear gives 0 with flags 0100. Complement gives the bitwise inverse with V=0 and C=1. Test leaves `result` unchanged and sets N and Z from the operand, with V=0 and C=0.
- R5: Increment and decrement add or subtract one modulo the width, and C follows `c_in`. Increment sets V only from 077777 (byte 0x7F). Decrement sets V only from 100000 (byte 0x80).
- R6: Negate gives the two's complement. C=1 when the result is nonzero. V=1 when the result is the most negative value.
- R7: Arithmetic shift right keeps the sign bit. Shift left inserts a zero. In both, the bit shifted out goes to C.
- R8: Rotate right and rotate left move through the carry: `c_in` enters at the vacated end, and the bit leaving goes to C.
- R9: After any shift or rotate, V equals N XOR C of the new flags.
- R10: Byte exchange swaps the two bytes of the full word whatever `byte_mode` is. N and Z come from the new low byte, and V=C=0.
- R11: Add carry adds `c_in`. V=1 only for operand 077777 (byte 0x7F) with `c_in`=1, and C=1 only for an all-ones operand with `c_in`=1. Subtract carry subtracts `c_in`. V=1 only for 100000 (byte 0x80) with `c_in`=1, and C=1 only for a zero operand with `c_in`=1.
- R12: Sign extend fills the operated width with `n_in`. N equals `n_in`, Z equals its inverse, V=0, and C follows `c_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Capture strobe for this cycle's operation |
| byte_mode | input | 1 | 1 = byte form, 0 = word form |
| op | input | 4 | Operation code |
| operand | input | 16 | Source value |
| c_in | input | 1 | Current carry flag |
| n_in | input | 1 | Current negative flag |
| result | output | 16 | Registered result |
| flags | output | 4 | Registered {N,Z,V,C} |
| done | output | 1 | High one cycle after a captured operation |

## Verification
The assertions assume that `op` carries one of the fourteen defined codes, since codes 14 and 15 have no defined behaviour. They also assume that `operand`, `op` and `byte_mode` are defined in the cycle before a `valid` edge, because several properties compare the output against that cycle's operand. The stimulus drives only defined codes. It changes inputs at the falling edge, so they are stable at every rising edge. It sweeps every byte value and a strided set of word values that includes the signed and unsigned limits.

// File: rtl/sop_pkg.sv
package sop_pkg;
    localparam int DATA_W = 16;

    typedef enum logic [3:0] {
        OP_CLR  = 4'd0,
        OP_TST  = 4'd1,
        OP_INC  = 4'd2,
        OP_DEC  = 4'd3,
        OP_NEG  = 4'd4,
        OP_COM  = 4'd5,
        OP_ASR  = 4'd6,
        OP_ASL  = 4'd7,
        OP_ROR  = 4'd8,
        OP_ROL  = 4'd9,
        OP_SWAB = 4'd10,
        OP_ADC  = 4'd11,
        OP_SBC  = 4'd12,
        OP_SXT  = 4'd13
    } op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    function automatic logic is_shift(op_e o);
        return (o == OP_ASR) || (o == OP_ASL) || (o == OP_ROR) || (o == OP_ROL);
    endfunction
endpackage

// File: rtl/sop_lane.sv
module sop_lane
    import sop_pkg::*;
#(
    parameter int W = 16
) (
    input  op_e            op,
    input  logic [W-1:0]   a,
    input  logic           cin,
    input  logic           nin,
    output logic [W-1:0]   res,
    output flags_t         fl
);
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] SMAX = ~SMIN;
    localparam logic [W-1:0] ONES = {W{1'b1}};
    localparam logic [W-1:0] ZERO = {W{1'b0}};

    logic c_nx;
    logic v_nx;

    always_comb begin
        res  = a;
        c_nx = cin;
        v_nx = 1'b0;
        case (op)
            OP_CLR: begin res = ZERO; c_nx = 1'b0; end
            OP_TST: begin res = a; c_nx = 1'b0; end
            OP_INC: begin res = a + 1'b1; v_nx = (a == SMAX); end
            OP_DEC: begin res = a - 1'b1; v_nx = (a == SMIN); end
            OP_NEG: begin
                res  = ZERO - a;
                v_nx = (a == SMIN);
                c_nx = (a != ZERO);
            end
            OP_COM: begin res = ~a; c_nx = 1'b1; end
            OP_ASR: begin res = {a[W-1], a[W-1:1]}; c_nx = a[0]; end
            OP_ASL: begin res = {a[W-2:0], 1'b0}; c_nx = a[W-1]; end
            OP_ROR: begin res = {cin, a[W-1:1]}; c_nx = a[0]; end
            OP_ROL: begin res = {a[W-2:0], cin}; c_nx = a[W-1]; end
            OP_ADC: begin
                res  = a + {{(W-1){1'b0}}, cin};
                v_nx = cin && (a == SMAX);
                c_nx = cin && (a == ONES);
            end
            OP_SBC: begin
                res  = a - {{(W-1){1'b0}}, cin};
                v_nx = cin && (a == SMIN);
                c_nx = cin && (a == ZERO);
            end
            OP_SXT: res = {W{nin}};
            default: res = a;
        endcase
    end

    always_comb begin
        fl.n = res[W-1];
        fl.z = (res == ZERO);
        fl.c = c_nx;
        fl.v = is_shift(op) ? (res[W-1] ^ c_nx) : v_nx;
    end
endmodule

// File: rtl/sop_alu_top.sv
module sop_alu_top
    import sop_pkg::*;
#(
    parameter int DW = sop_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic          byte_mode,
    input  logic [3:0]    op,
    input  logic [DW-1:0] operand,
    input  logic          c_in,
    input  logic          n_in,
    output logic [DW-1:0] result,
    output logic [3:0]    flags,
    output logic          done
);
    localparam int H = DW / 2;

    op_e            op_i;
    logic [DW-1:0]  w_res;
    flags_t         w_fl;
    logic [H-1:0]   b_res;
    flags_t         b_fl;
    logic [DW-1:0]  nxt_res;
    flags_t         nxt_fl;
    logic [DW-1:0]  swapped;
    flags_t         fl_q;

    assign op_i    = op_e'(op);
    assign swapped = {operand[H-1:0], operand[DW-1:H]};

    sop_lane #(.W(DW)) u_word_lane (
        .op(op_i), .a(operand), .cin(c_in), .nin(n_in),
        .res(w_res), .fl(w_fl)
    );

    sop_lane #(.W(H)) u_byte_lane (
        .op(op_i), .a(operand[H-1:0]), .cin(c_in), .nin(n_in),
        .res(b_res), .fl(b_fl)
    );

    always_comb begin
        if (op_i == OP_SWAB) begin
            nxt_res  = swapped;
            nxt_fl.n = swapped[H-1];
            nxt_fl.z = (swapped[H-1:0] == '0);
            nxt_fl.v = 1'b0;
            nxt_fl.c = 1'b0;
        end else if (byte_mode) begin
            nxt_res = {operand[DW-1:H], b_res};
            nxt_fl  = b_fl;
        end else begin
            nxt_res = w_res;
            nxt_fl  = w_fl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            fl_q   <= '0;
            done   <= 1'b0;
        end else begin
            done <= valid;
            if (valid) begin
                fl_q <= nxt_fl;
                if (op_i != OP_TST) result <= nxt_res;
            end
        end
    end

    assign flags = fl_q;

    assert_done_R2: assert property (@(posedge clk) disable iff (rst)
        valid |=> done);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !valid |=> ($stable(result) && $stable(flags) && !done));
    assert_upper_R3: assert property (@(posedge clk) disable iff (rst)
        (valid && byte_mode && op_i != OP_SWAB && op_i != OP_TST)
        |=> result[DW-1:H] == $past(operand[DW-1:H]));
    assert_clr_R4: assert property (@(posedge clk) disable iff (rst)
        (valid && op_i == OP_CLR) |=> (flags == 4'b0100));
    assert_tst_R4: assert property (@(posedge clk) disable iff (rst)
        (valid && op_i == OP_TST) |=> ($stable(result) && flags[1:0] == 2'b00));
    assert_shiftv_R9: assert property (@(posedge clk) disable iff (rst)
        (valid && is_shift(op_i)) |=> (flags[1] == (flags[3] ^ flags[0])));
    assert_swab_R10: assert property (@(posedge clk) disable iff (rst)
        (valid && op_i == OP_SWAB)
        |=> (flags[1:0] == 2'b00 &&
             result == {$past(operand[H-1:0]), $past(operand[DW-1:H])}));
endmodule

// File: tb/sop_alu_top_bench.sv
module sop_alu_top_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid;
    logic        byte_mode;
    logic [3:0]  op;
    logic [15:0] operand;
    logic        c_in;
    logic        n_in;
    logic [15:0] result;
    logic [3:0]  flags;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] prev_res;

    always #10 clk = ~clk;

    sop_alu_top u_sop_alu_top (
        .clk(clk), .rst(rst), .valid(valid), .byte_mode(byte_mode),
        .op(op), .operand(operand), .c_in(c_in), .n_in(n_in),
        .result(result), .flags(flags), .done(done)
    );

    function automatic string tag_of(int o);
        case (o)
            0, 1, 5: return "R4";
            2, 3:    return "R5";
            4:       return "R6";
            6, 7:    return "R7";
            8, 9:    return "R8";
            10:      return "R10";
            11, 12:  return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (op=%0d byte=%0b a=%h c=%0b n=%0b)",
                     req, act, exp, op, byte_mode, operand, c_in, n_in);
        end
    endtask

    task automatic model(input int o, input bit byt, input logic [15:0] a,
                         input bit ci, input bit ni, input logic [15:0] prev,
                         output logic [15:0] r, output logic [3:0] f);
        int w, mask, smin, x, y;
        bit n, z, v, c;
        w    = byt ? 8 : 16;
        mask = (1 << w) - 1;
        smin = 1 << (w - 1);
        x    = byt ? int'(a[7:0]) : int'(a);
        y    = x;
        c    = ci;
        v    = 1'b0;
        if (o == 10) begin
            r = {a[7:0], a[15:8]};
            f = {r[7], r[7:0] == 8'h00, 2'b00};
            return;
        end
        case (o)
            0:  begin y = 0; c = 0; end
            1:  begin y = x; c = 0; end
            2:  begin y = (x + 1) & mask; v = (x == smin - 1); end
            3:  begin y = (x - 1) & mask; v = (x == smin); end
            4:  begin y = (-x) & mask; v = (y == smin); c = (y != 0); end
            5:  begin y = (~x) & mask; c = 1; end
            6:  begin y = (x >> 1) | (x & smin); c = (x & 1) != 0; end
            7:  begin y = (x << 1) & mask; c = (x & smin) != 0; end
            8:  begin y = (x >> 1) | (ci ? smin : 0); c = (x & 1) != 0; end
            9:  begin y = ((x << 1) | int'(ci)) & mask; c = (x & smin) != 0; end
            11: begin y = (x + int'(ci)) & mask; v = ci && (x == smin - 1); c = ci && (x == mask); end
            12: begin y = (x - int'(ci)) & mask; v = ci && (x == smin); c = ci && (x == 0); end
            default: y = ni ? mask : 0;
        endcase
        n = (y & smin) != 0;
        z = (y == 0);
        if (o >= 6 && o <= 9) v = n ^ c;
        if (o == 1)      r = prev;
        else if (byt)    r = {a[15:8], 8'(y)};
        else             r = 16'(y);
        f = {n, z, v, c};
    endtask

    task automatic apply(int o, bit byt, logic [15:0] a, bit ci, bit ni);
        logic [15:0] er;
        logic [3:0]  ef;
        model(o, byt, a, ci, ni, prev_res, er, ef);
        @(negedge clk);
        valid = 1'b1; op = 4'(o); byte_mode = byt; operand = a; c_in = ci; n_in = ni;
        @(posedge clk);
        @(negedge clk);
        valid = 1'b0;
        check({tag_of(o), byt ? "/R3" : ""}, {16'h0, result}, {16'h0, er});
        check({tag_of(o), byt ? "/R3 flags" : " flags"}, {28'h0, flags}, {28'h0, ef});
        check("R2 done", {31'h0, done}, 32'h1);
        if (o >= 6 && o <= 9)   // R9: V = N xor C after shifts and rotates
            check("R9", {31'h0, flags[1]}, {31'h0, flags[3] ^ flags[0]});
        prev_res = er;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] corners [6];
        corners = '{16'h7FFF, 16'h8000, 16'hFFFF, 16'h0001, 16'h7F80, 16'h0080};
        rst = 1'b1; valid = 1'b0; byte_mode = 1'b0; op = 4'd0;
        operand = 16'h0; c_in = 1'b0; n_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 result", {16'h0, result}, 32'h0);
        check("R1 flags", {28'h0, flags}, 32'h0);
        check("R1 done", {31'h0, done}, 32'h0);
        rst = 1'b0;
        prev_res = 16'h0;

        for (int o = 0; o < 14; o++)
            for (int v = 0; v < 256; v++)
                for (int k = 0; k < 4; k++)
                    apply(o, 1'b1, {8'(v * 37 + 5), 8'(v)}, k[0], k[1]);

        for (int o = 0; o < 14; o++) begin
            for (int v = 0; v < 65536; v += 257)
                for (int k = 0; k < 4; k++)
                    apply(o, 1'b0, 16'(v), k[0], k[1]);
            for (int i = 0; i < 6; i++)
                for (int k = 0; k < 4; k++)
                    apply(o, 1'b0, corners[i], k[0], k[1]);
        end

        // R2: without valid, new inputs must not reach the outputs
        apply(2, 1'b0, 16'h1234, 1'b0, 1'b0);
        @(negedge clk);
        op = 4'd5; operand = 16'hAAAA; byte_mode = 1'b0; c_in = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R2 hold result", {16'h0, result}, 32'h1235);
        check("R2 hold flags", {28'h0, flags}, 32'h0);
        check("R2 done low", {31'h0, done}, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule